// File: doc/BRIEF.md
# Watchdog Timer with Pulse or Toggle Output

A single-channel up-counting watchdog timer. Software-visible registers live outside the block. The block sees them as plain inputs: the enable bit, a 4-bit mode code, the load value with a write strobe, the compare value, the reload and invert control bits, and the interrupt enables. While enabled in one of its two watchdog modes, the block advances on timer ticks. A tick comes from either an internal divide-by-two of the clock or an external pre-divided tick input.

On enable the count is zero. The first tick loads the programmed start value and each later tick adds one. A tick that leaves the count equal to the compare value raises a sticky compare flag. If reload is selected, the tick after such a match brings the count back to the start value. When the count rolls over from all ones to zero, a sticky overflow flag is raised and the output pin reacts. In pulse mode the pin leaves its idle level for one tick period. In toggle mode the pin flips on every rollover. The idle level equals the invert bit, so the first edge always moves away from it.

Top module: `wdt_timer`

## Requirements
- R1: Only mode code 4'b1001 (pulse output) and 4'b1010 (toggle output) run the timer. With any other code, or with enable low, the count stays 0, no flag is set and the pin sits at the invert level.
- R2: While the timer is stopped the count is 0. The first tick after it starts loads `load_val_i`, and each later tick adds 1 modulo 2^CNT_W.
- R3: With `src_sel_i`=0, a tick occurs on every second clock: the first one is on the second rising edge after the timer starts running. With `src_sel_i`=1, a tick occurs on each rising edge where `ext_tick_i` is high.
- R4: A tick that leaves the count equal to `cmp_val_i` sets `cmp_flag_o`. `cmp_irq_o` equals `cmp_flag_o` AND `cmp_irq_en_i`.
- R5: On the tick after a compare match, the count is set to `load_val_i` when `reload_en_i`=1. When `reload_en_i`=0 it keeps adding 1.
- R6: A `load_wr_i` strobe while running sets the count to `load_val_i` on that edge. This takes priority over a tick, discards any pending reload, and raises no compare.
- R7: A tick that takes the count from all ones to 0 sets `ovf_flag_o`. `ovf_irq_o` equals `ovf_flag_o` AND `ovf_irq_en_i`.
- R8: Both flags stay set until their clear strobe (`clr_cmp_i`, `clr_ovf_i`) is high at a clock edge. A set and a clear in the same cycle leave the flag set. Stopping the timer does not clear the flags.
- R9: While stopped, `pin_o` follows `invert_i` one clock later. In pulse mode a rollover drives `pin_o` to NOT `invert_i` until the next tick, which restores `invert_i`. In toggle mode each rollover inverts `pin_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Timer enable |
| mode_i | input | 4 | Mode code (4'b1001 pulse, 4'b1010 toggle) |
| src_sel_i | input | 1 | Tick source: 0 clock/2, 1 external tick |
| ext_tick_i | input | 1 | External pre-divided tick, one clock wide per tick |
| invert_i | input | 1 | Output polarity / idle level |
| reload_en_i | input | 1 | Reload start value on the tick after a match |
| load_val_i | input | CNT_W | Start value |
| load_wr_i | input | 1 | Start-value write strobe |
| cmp_val_i | input | CNT_W | Compare value |
| cmp_irq_en_i | input | 1 | Compare interrupt enable |
| ovf_irq_en_i | input | 1 | Overflow interrupt enable |
| clr_cmp_i | input | 1 | Clear compare flag |
| clr_ovf_i | input | 1 | Clear overflow flag |
| count_o | output | CNT_W | Live count |
| cmp_flag_o | output | 1 | Sticky compare flag |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_irq_o | output | 1 | Compare interrupt |
| ovf_irq_o | output | 1 | Overflow interrupt |
| pin_o | output | 1 | Watchdog output pin |

## Verification
The bench builds the block with CNT_W=8 instead of the default 24. This makes a full rollover only 256 ticks long, so several wraps in both output modes fit in a short run. It also lets the bench reach wraps that start from a loaded value just below all ones and wraps that follow a long irregular stretch of external ticks. Compare values near the top of the range and at zero put matches, reloads and rollovers close together. This exercises the reload-versus-increment choice and pulse restoration within a few ticks of each other.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [3:0] {
    WDT_PULSE  = 4'b1001,
    WDT_TOGGLE = 4'b1010
  } wdt_mode_e;

  function automatic logic mode_ok(input logic [3:0] m);
    return (m == WDT_PULSE) || (m == WDT_TOGGLE);
  endfunction

  function automatic logic mode_is_pulse(input logic [3:0] m);
    return m == WDT_PULSE;
  endfunction
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic src_sel,
  input  logic ext_tick,
  output logic tick
);
  logic div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= 1'b0;
    else if (!run) div_q <= 1'b0;
    else           div_q <= ~div_q;
  end

  assign tick = run && (src_sel ? ext_tick : div_q);

  // R3: internal source never ticks on two clocks in a row
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_sel && tick) |=> (src_sel || !tick));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             reload_en,
  output logic [CNT_W-1:0] cnt,
  output logic             cmp_evt,
  output logic             ovf_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, nxt;
  logic             first_q, pend_q, take_load, wrap;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic [CNT_W-1:0] start,
                                            input logic             use_start);
    return use_start ? start : cur + 1'b1;
  endfunction

  assign take_load = first_q || (pend_q && reload_en);
  assign nxt       = step(cnt_q, load_val, take_load);
  assign wrap      = !take_load && (cnt_q == CNT_MAX);
  assign cmp_evt   = run && !load_wr && tick && (nxt == cmp_val);
  assign ovf_evt   = run && !load_wr && tick && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; first_q <= 1'b1; pend_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0; first_q <= 1'b1; pend_q <= 1'b0;
    end else if (load_wr) begin
      cnt_q <= load_val; first_q <= 1'b0; pend_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= nxt; first_q <= 1'b0; pend_q <= cmp_evt;
    end
  end

  assign cnt = cnt_q;

  // R2: first tick after start applies the start value
  p_first_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && first_q && !load_wr) |=> (cnt_q == $past(load_val)));
  // R5: pending match with reload enabled brings back the start value
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !first_q && pend_q && reload_en && !load_wr) |=> (cnt_q == $past(load_val)));
  // R6: a write while running lands on the same edge
  p_load_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && load_wr) |=> (cnt_q == $past(load_val)));
  // R7: a rollover always leaves zero
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_flags.sv
module wdt_flags #(
  parameter int N_FLAG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_FLAG-1:0] set,
  input  logic [N_FLAG-1:0] clr,
  output logic [N_FLAG-1:0] q
);
  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
    // R8: a flag only drops through its clear strobe
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !clr[i]) |=> q[i]);
  end
endmodule

// File: rtl/wdt_pin.sv
module wdt_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic ovf_evt,
  input  logic pulse_mode,
  input  logic invert,
  output logic pin
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pin_q <= 1'b0;
    else if (!run)                 pin_q <= invert;
    else if (ovf_evt)              pin_q <= pulse_mode ? ~invert : ~pin_q;
    else if (tick && pulse_mode)   pin_q <= invert;
  end

  assign pin = pin_q;

  // R9: stopped pin follows the idle level
  p_idle_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pin_q == $past(invert)));
  // R9: toggle-mode rollover flips the pin
  p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !pulse_mode) |=> (pin_q != $past(pin_q)));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic [3:0]       mode_i,
  input  logic             src_sel_i,
  input  logic             ext_tick_i,
  input  logic             invert_i,
  input  logic             reload_en_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             load_wr_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             cmp_irq_en_i,
  input  logic             ovf_irq_en_i,
  input  logic             clr_cmp_i,
  input  logic             clr_ovf_i,
  output logic [CNT_W-1:0] count_o,
  output logic             cmp_flag_o,
  output logic             ovf_flag_o,
  output logic             cmp_irq_o,
  output logic             ovf_irq_o,
  output logic             pin_o
);
  import wdt_pkg::*;

  logic       run, pulse_mode, tick, cmp_evt, ovf_evt;
  logic [1:0] flag_q;

  assign run        = enable_i && mode_ok(mode_i);
  assign pulse_mode = mode_is_pulse(mode_i);

  wdt_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .src_sel(src_sel_i),
    .ext_tick(ext_tick_i), .tick(tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .load_wr(load_wr_i),
    .load_val(load_val_i), .cmp_val(cmp_val_i), .reload_en(reload_en_i),
    .cnt(count_o), .cmp_evt(cmp_evt), .ovf_evt(ovf_evt)
  );

  wdt_flags #(.N_FLAG(2)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set({ovf_evt, cmp_evt}), .clr({clr_ovf_i, clr_cmp_i}), .q(flag_q)
  );

  wdt_pin u_pin (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .ovf_evt(ovf_evt),
    .pulse_mode(pulse_mode), .invert(invert_i), .pin(pin_o)
  );

  assign cmp_flag_o = flag_q[0];
  assign ovf_flag_o = flag_q[1];
  assign cmp_irq_o  = cmp_flag_o && cmp_irq_en_i;
  assign ovf_irq_o  = ovf_flag_o && ovf_irq_en_i;

  // R1, R2: a stopped timer holds zero
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count_o == '0));
  // R4: a compare event is visible as the flag on the next cycle
  p_cmp_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> cmp_flag_o);
  // R7: a rollover event is visible as the flag on the next cycle
  p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag_o);
  // R1: no events without a valid running mode
  p_no_evt_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!cmp_evt && !ovf_evt));
endmodule

// File: tb/wdt_timer_tb.sv
module wdt_timer_tb;
  localparam int W = 8;
  localparam int MOD = 1 << W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable_i = 0, src_sel_i = 0, ext_tick_i = 0, invert_i = 0, reload_en_i = 0;
  logic [3:0] mode_i = 4'b0000;
  logic [W-1:0] load_val_i = '0, cmp_val_i = '0;
  logic load_wr_i = 0, cmp_irq_en_i = 0, ovf_irq_en_i = 0, clr_cmp_i = 0, clr_ovf_i = 0;
  logic [W-1:0] count_o;
  logic cmp_flag_o, ovf_flag_o, cmp_irq_o, ovf_irq_o, pin_o;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  wdt_timer #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .mode_i(mode_i),
    .src_sel_i(src_sel_i), .ext_tick_i(ext_tick_i), .invert_i(invert_i),
    .reload_en_i(reload_en_i), .load_val_i(load_val_i), .load_wr_i(load_wr_i),
    .cmp_val_i(cmp_val_i), .cmp_irq_en_i(cmp_irq_en_i), .ovf_irq_en_i(ovf_irq_en_i),
    .clr_cmp_i(clr_cmp_i), .clr_ovf_i(clr_ovf_i), .count_o(count_o),
    .cmp_flag_o(cmp_flag_o), .ovf_flag_o(ovf_flag_o), .cmp_irq_o(cmp_irq_o),
    .ovf_irq_o(ovf_irq_o), .pin_o(pin_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state, written from the requirements
  int  m_cnt = 0, m_phase = 0;
  bit  m_started = 0, m_match = 0, m_pin = 0, m_cf = 0, m_of = 0;

  always @(posedge clk) begin
    bit running, tk, is_pulse, c_ev, o_ev;
    running  = enable_i && (mode_i == 4'd9 || mode_i == 4'd10);
    is_pulse = (mode_i == 4'd9);
    c_ev = 0; o_ev = 0;
    if (!rst_n) begin
      m_cnt = 0; m_phase = 0; m_started = 0; m_match = 0; m_pin = 0; m_cf = 0; m_of = 0;
    end else begin
      tk = running && (src_sel_i ? ext_tick_i : (m_phase % 2 == 1));
      if (!running) begin
        m_cnt = 0; m_phase = 0; m_started = 0; m_match = 0; m_pin = invert_i;
      end else begin
        m_phase++;
        if (load_wr_i) begin
          m_cnt = load_val_i; m_started = 1; m_match = 0;
        end else if (tk) begin
          if (!m_started || (m_match && reload_en_i)) m_cnt = load_val_i;
          else if (m_cnt == MOD - 1) begin m_cnt = 0; o_ev = 1; end
          else m_cnt = m_cnt + 1;
          m_started = 1;
          c_ev = (m_cnt == cmp_val_i);
          m_match = c_ev;
        end
        if (o_ev) m_pin = is_pulse ? !invert_i : !m_pin;
        else if (tk && is_pulse) m_pin = invert_i;
      end
      if (c_ev) m_cf = 1; else if (clr_cmp_i) m_cf = 0;
      if (o_ev) m_of = 1; else if (clr_ovf_i) m_of = 0;
    end
    #2;
    chk("R2 count vs model", count_o, m_cnt);
    chk("R4 cmp flag vs model", cmp_flag_o, m_cf);
    chk("R7 ovf flag vs model", ovf_flag_o, m_of);
    chk("R4 cmp irq vs model", cmp_irq_o, m_cf && cmp_irq_en_i);
    chk("R7 ovf irq vs model", ovf_irq_o, m_of && ovf_irq_en_i);
    chk("R9 pin vs model", pin_o, m_pin);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic after_edges(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R2 reset count", count_o, 0);
    chk("R8 reset flags", {cmp_flag_o, ovf_flag_o}, 0);
    rst_n = 1;
    cyc(2);
    chk("R9 idle pin", pin_o, 0);

    // R1: enabled with an unused mode code
    mode_i = 4'b0011; enable_i = 1; load_val_i = 8'hF0; cmp_val_i = 8'hF0;
    cyc(30);
    chk("R1 bad mode count", count_o, 0);
    chk("R1 bad mode flag", cmp_flag_o, 0);
    enable_i = 0; cyc(2);

    // pulse mode, internal tick
    mode_i = 4'b1001; src_sel_i = 0; load_val_i = 8'hF0; cmp_val_i = 8'hF4;
    cmp_irq_en_i = 1; ovf_irq_en_i = 0; invert_i = 0;
    @(negedge clk); enable_i = 1;
    after_edges(1);
    chk("R3 no tick on first edge", count_o, 0);
    after_edges(1);
    chk("R3 load on second edge", count_o, 8'hF0);
    after_edges(2);
    chk("R2 increment", count_o, 8'hF1);
    cyc(40);
    chk("R4 cmp flag", cmp_flag_o, 1);
    chk("R4 cmp irq", cmp_irq_o, 1);
    chk("R7 ovf flag", ovf_flag_o, 1);
    chk("R7 ovf irq gated", ovf_irq_o, 0);

    // R8: clearing
    clr_cmp_i = 1; clr_ovf_i = 1; cyc(1); clr_cmp_i = 0; clr_ovf_i = 0;
    chk("R8 cleared", {cmp_flag_o, ovf_flag_o}, 0);

    // R6: load write while running
    load_val_i = 8'h10; cmp_val_i = 8'h14; reload_en_i = 1; load_wr_i = 1;
    after_edges(1);
    chk("R6 load write", count_o, 8'h10);
    @(negedge clk); load_wr_i = 0;

    // R5: reload keeps count in [0x10, 0x14]
    for (int i = 0; i < 40; i++) begin
      cyc(1);
      chk("R5 reload window", (count_o >= 8'h10) && (count_o <= 8'h14), 1);
    end

    // stop: count zero, pin idle, flags kept
    enable_i = 0; cyc(1);
    chk("R2 stopped count", count_o, 0);
    chk("R9 stopped pin", pin_o, 0);
    chk("R8 flag kept on stop", cmp_flag_o, 1);
    clr_cmp_i = 1; clr_ovf_i = 1; cyc(1); clr_cmp_i = 0; clr_ovf_i = 0;

    // toggle mode, external tick, inverted
    invert_i = 1; mode_i = 4'b1010; src_sel_i = 1; reload_en_i = 0;
    load_val_i = 8'hFE; cmp_val_i = 8'h00; ovf_irq_en_i = 1;
    cyc(1);
    chk("R9 idle inverted", pin_o, 1);
    enable_i = 1; ext_tick_i = 1;
    after_edges(3);
    chk("R9 first toggle low", pin_o, 0);
    chk("R7 ovf irq", ovf_irq_o, 1);
    chk("R4 match at zero", cmp_flag_o, 1);
    @(negedge clk); ext_tick_i = 0;
    for (int i = 0; i < 1500; i++) begin
      ext_tick_i = ($urandom % 3) == 0;
      cyc(1);
    end
    ext_tick_i = 0; enable_i = 0; cyc(2);

    // pulse mode, external tick, inverted
    mode_i = 4'b1001; load_val_i = 8'hFD;
    @(negedge clk); enable_i = 1; ext_tick_i = 1;
    after_edges(4);
    chk("R9 pulse active", pin_o, 0);
    after_edges(1);
    chk("R9 pulse ends after one tick", pin_o, 1);
    @(negedge clk); ext_tick_i = 0;
    cyc(5);
    for (int i = 0; i < 900; i++) begin
      ext_tick_i = ($urandom % 2) == 0;
      cmp_val_i = (i % 300 == 0) ? 8'hFF : cmp_val_i;
      cyc(1);
    end
    ext_tick_i = 0; enable_i = 0; cyc(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule